// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block holds the interrupt state for a 16-bit timer that has four event sources: input capture, compare match B, compare match A and counter overflow. The timer core delivers each event as a single-cycle pulse. The block stores each pulse in a sticky flag. It then gates every flag with its own enable bit and with a global interrupt-enable input, which gives one request line per source and one combined request line.

Software reaches two byte-wide registers over a small register bus made of an address, a write strobe, write data and combinational read data.

- The enable register is plain read/write storage.
- The flag register is cleared by writing ones to it.
- A flag also clears when the vector for its source is taken. Each source has its own acknowledge pulse for this.

The capture flag can be set from one of two places: the capture pin event, or the counter-at-TOP pulse. The second is used when the capture register serves as the counter's TOP value. A mode input picks which of the two is honoured.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and irq_req and irq_any are 0.
- R2: Bits 7, 6, 4 and 3 of both registers always read zero and writes to them have no effect. Any address other than 0 (enable register) and 1 (flag register) reads 0x00.
- R3: The enable register is read/write on bits 5 (capture), 2 (compare B), 1 (compare A) and 0 (overflow). A write takes effect at the next clock edge.
- R4: An event pulse sets its flag at the next clock edge, and the flag stays set until it is cleared. The flag register uses the same bit positions as the enable register.
- R5: Writing a one to a flag bit clears that flag. Writing a zero to a flag bit leaves it unchanged.
- R6: An acknowledge pulse clears the flag of its source. ack bit 0 is overflow, bit 1 is compare A, bit 2 is compare B and bit 3 is capture.
- R7: When a set event and a clear (a write-one or an acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R8: With cap_top_mode = 0, only ev_cap_pin sets the capture flag. With cap_top_mode = 1, only ev_cap_top sets it. The source that is not selected is ignored.
- R9: irq_req[i] is 1 exactly when flag i is set, enable bit i is set and gie is 1. The index order is 0 overflow, 1 compare A, 2 compare B, 3 capture.
- R10: irq_any is the OR of the four irq_req bits.
- R11: Reading a register has no side effect. Repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| bus_addr | input | ADDR_W | Register address (0 enable, 1 flags) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| gie | input | 1 | Global interrupt enable |
| cap_top_mode | input | 1 | 1: the capture flag follows the counter-at-TOP pulse |
| ev_cap_pin | input | 1 | Capture pin event pulse |
| ev_cap_top | input | 1 | Counter reached TOP pulse |
| ev_cmp_b | input | 1 | Compare match B pulse |
| ev_cmp_a | input | 1 | Compare match A pulse |
| ev_ovf | input | 1 | Overflow pulse |
| ack | input | 4 | Per-source vector acknowledge pulses |
| irq_req | output | 4 | Per-source interrupt requests |
| irq_any | output | 1 | OR of all requests |

## Verification
The hardest case to reach from the ports is a set event and a clear landing on the same flag in the same cycle. It must be tried once with a write-one clear and once with an acknowledge. The stimulus table therefore has rows that drive an event pulse, a flag-register write and an acknowledge together in one cycle, and the flag register is read back afterwards.

The capture-source selection is exercised the same way. Each mode is driven with a pulse on the source it should ignore. Where needed, an acknowledge in the same row clears the flag so that a wrongly honoured pulse would show up in the readback.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC   = 4;
  localparam int DATA_W = 8;

  // register bit position for source index (0 ovf, 1 cmp A, 2 cmp B, 3 capture)
  function automatic int src_pos(input int i);
    case (i)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 5;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] to_reg(input logic [NSRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) r[src_pos(i)] = v[i];
    return r;
  endfunction

  function automatic logic [NSRC-1:0] from_reg(input logic [DATA_W-1:0] r);
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) v[i] = r[src_pos(i)];
    return v;
  endfunction

  // sticky flag update: a set always wins over a clear
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic [NSRC-1:0] req_of(input logic [NSRC-1:0] flags,
                                             input logic [NSRC-1:0] en,
                                             input logic glob);
    return flags & en & {NSRC{glob}};
  endfunction
endpackage

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import tmr_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= flag_next(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/tmr_irq_capsel.sv
module tmr_irq_capsel (
  input  logic top_mode_i,
  input  logic pin_ev_i,
  input  logic top_ev_i,
  output logic cap_set_o
);
  always_comb begin
    if (top_mode_i) cap_set_o = top_ev_i;
    else            cap_set_o = pin_ev_i;
  end
endmodule

// File: rtl/tmr_irq_regif.sv
module tmr_irq_regif #(
  parameter int ADDR_W    = 2,
  parameter int EN_ADDR   = 0,
  parameter int FLAG_ADDR = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic                               wr_i,
  input  logic [tmr_irq_pkg::DATA_W-1:0]     wdata_i,
  input  logic [tmr_irq_pkg::NSRC-1:0]       flag_i,
  output logic [tmr_irq_pkg::NSRC-1:0]       en_o,
  output logic [tmr_irq_pkg::NSRC-1:0]       w1c_o,
  output logic [tmr_irq_pkg::DATA_W-1:0]     rdata_o
);
  import tmr_irq_pkg::*;

  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

  logic sel_en, sel_flag;
  logic [NSRC-1:0] wr_bits;

  assign sel_en   = (addr_i == EN_A);
  assign sel_flag = (addr_i == FLAG_A);

  always_comb begin
    wr_bits = '0;
    for (int b = 0; b < DATA_W; b++) begin
      for (int i = 0; i < NSRC; i++) begin
        if (src_pos(i) == b) wr_bits[i] = wdata_i[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              en_o <= '0;
    else if (wr_i && sel_en) en_o <= wr_bits;
  end

  assign w1c_o = (wr_i && sel_flag) ? wr_bits : '0;

  always_comb begin
    if (sel_en)        rdata_o = to_reg(en_o);
    else if (sel_flag) rdata_o = to_reg(flag_i);
    else               rdata_o = '0;
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int ADDR_W    = 2,
  parameter int EN_ADDR   = 0,
  parameter int FLAG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              gie,
  input  logic              cap_top_mode,
  input  logic              ev_cap_pin,
  input  logic              ev_cap_top,
  input  logic              ev_cmp_b,
  input  logic              ev_cmp_a,
  input  logic              ev_ovf,
  input  logic [3:0]        ack,
  output logic [3:0]        irq_req,
  output logic              irq_any
);
  import tmr_irq_pkg::*;

  // named internal events, visible to the bound checker
  logic            cap_set;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] w1c_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_vec;
  logic [NSRC-1:0] en_vec;

  tmr_irq_capsel u_capsel (
    .top_mode_i (cap_top_mode),
    .pin_ev_i   (ev_cap_pin),
    .top_ev_i   (ev_cap_top),
    .cap_set_o  (cap_set)
  );

  assign set_vec = {cap_set, ev_cmp_b, ev_cmp_a, ev_ovf};
  assign clr_vec = w1c_vec | ack;

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    tmr_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (flag_vec[g])
    );
  end

  tmr_irq_regif #(
    .ADDR_W    (ADDR_W),
    .EN_ADDR   (EN_ADDR),
    .FLAG_ADDR (FLAG_ADDR)
  ) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .flag_i  (flag_vec),
    .en_o    (en_vec),
    .w1c_o   (w1c_vec),
    .rdata_o (bus_rdata)
  );

  assign irq_req = req_of(flag_vec, en_vec, gie);
  assign irq_any = |irq_req;
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       cap_top_mode,
  input logic       ev_cap_pin,
  input logic       ev_cap_top,
  input logic [3:0] set_vec,
  input logic [3:0] clr_vec,
  input logic [3:0] flag_vec,
  input logic [3:0] en_vec,
  input logic [3:0] irq_req,
  input logic       irq_any,
  input logic [7:0] bus_rdata
);
  // R2: reserved read bits
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 8'hD8) == 8'h00);

  // R4 and R7: every set event is visible on the next cycle
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 4'b0) |=> ((flag_vec & $past(set_vec)) == $past(set_vec)));

  // R4: a flag rises only because of a set event
  a_r4_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_vec & ~$past(flag_vec)) & ~$past(set_vec)) == 4'b0);

  // R5 and R6: a clear without a set drops the flag
  a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != 4'b0) |=> ((flag_vec & $past(clr_vec & ~set_vec)) == 4'b0));

  // R8: the capture source that is not selected is ignored
  a_r8_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_top_mode && ev_cap_pin && !ev_cap_top && !flag_vec[3]) |=> !flag_vec[3]);
  a_r8_top_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_top_mode && ev_cap_top && !ev_cap_pin && !flag_vec[3]) |=> !flag_vec[3]);

  // R9: a request needs its flag, its enable and the global enable
  a_r9_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~(flag_vec & en_vec)) == 4'b0);
  a_r9_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == 4'b0));

  // R10: combined line
  a_r10_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_req != 4'b0));
endmodule

bind tmr_irq_ctrl tmr_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gie          (gie),
  .cap_top_mode (cap_top_mode),
  .ev_cap_pin   (ev_cap_pin),
  .ev_cap_top   (ev_cap_top),
  .set_vec      (set_vec),
  .clr_vec      (clr_vec),
  .flag_vec     (flag_vec),
  .en_vec       (en_vec),
  .irq_req      (irq_req),
  .irq_any      (irq_any),
  .bus_rdata    (bus_rdata)
);

// File: tb/sim_tmr_irq_ctrl.sv
`timescale 1ns/1ps
module sim_tmr_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0;
  logic       cap_top_mode = 1'b0;
  logic       ev_cap_pin = 1'b0, ev_cap_top = 1'b0, ev_cmp_b = 1'b0, ev_cmp_a = 1'b0, ev_ovf = 1'b0;
  logic [3:0] ack = '0;
  logic [3:0] irq_req;
  logic       irq_any;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .cap_top_mode(cap_top_mode), .ev_cap_pin(ev_cap_pin), .ev_cap_top(ev_cap_top),
    .ev_cmp_b(ev_cmp_b), .ev_cmp_a(ev_cmp_a), .ev_ovf(ev_ovf), .ack(ack),
    .irq_req(irq_req), .irq_any(irq_any)
  );

  // row: ev{pin,top,b,a,ovf}[25:21] mode[20] w1c[19:12] ack[11:8] expected flags[7:0]
  localparam int NV = 13;
  localparam logic [25:0] VT [NV] = '{
    {5'b00001, 1'b0, 8'h00, 4'b0000, 8'h01},  // R4 overflow
    {5'b00010, 1'b0, 8'h00, 4'b0000, 8'h03},  // R4 compare A
    {5'b00100, 1'b0, 8'h00, 4'b0000, 8'h07},  // R4 compare B
    {5'b10000, 1'b0, 8'h00, 4'b0000, 8'h27},  // R4 R8 capture pin
    {5'b00000, 1'b0, 8'h02, 4'b0000, 8'h25},  // R5 write-one
    {5'b00000, 1'b0, 8'hD8, 4'b0000, 8'h25},  // R5 R2 zeros and reserved
    {5'b00000, 1'b0, 8'h00, 4'b1000, 8'h05},  // R6 ack capture
    {5'b01000, 1'b0, 8'h00, 4'b0000, 8'h05},  // R8 top ignored in pin mode
    {5'b01000, 1'b1, 8'h00, 4'b0000, 8'h25},  // R8 top honoured
    {5'b10000, 1'b1, 8'h00, 4'b1000, 8'h05},  // R8 pin ignored in top mode
    {5'b00001, 1'b0, 8'h01, 4'b0000, 8'h05},  // R7 set beats write-one
    {5'b00010, 1'b0, 8'h00, 4'b0010, 8'h07},  // R7 set beats ack
    {5'b00000, 1'b0, 8'h27, 4'b0000, 8'h00}   // R5 clear all
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // called at a falling edge; one clock of stimulus, returns at the next falling edge
  task automatic cyc(input logic [4:0] ev, input logic mode, input logic wr,
                     input logic [1:0] a, input logic [7:0] wd, input logic [3:0] ak);
    {ev_cap_pin, ev_cap_top, ev_cmp_b, ev_cmp_a, ev_ovf} = ev;
    cap_top_mode = mode;
    bus_wr = wr; bus_addr = a; bus_wdata = wd; ack = ak;
    @(posedge clk);
    @(negedge clk);
    {ev_cap_pin, ev_cap_top, ev_cmp_b, ev_cmp_a, ev_ovf} = '0;
    bus_wr = 1'b0; ack = '0;
  endtask

  function automatic logic [3:0] exp_req(input logic [7:0] fl, input logic [7:0] en, input logic g);
    logic [3:0] r;
    r[0] = fl[0] && en[0] && g;
    r[1] = fl[1] && en[1] && g;
    r[2] = fl[2] && en[2] && g;
    r[3] = fl[5] && en[5] && g;
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 enable after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 flags after reset", d, 8'h00);
    chk("R1 irq_req after reset", {4'b0, irq_req}, 8'h00);
    chk("R1 irq_any after reset", {7'b0, irq_any}, 8'h00);

    // R3 R2 enable write
    cyc(5'b0, 1'b0, 1'b1, 2'd0, 8'hFF, 4'b0);
    rd(2'd0, d); chk("R3 R2 enable readback", d, 8'h27);
    gie = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VT[i];
      cyc(v[25:21], v[20], v[19:12] != 8'h00, 2'd1, v[19:12], v[11:8]);
      rd(2'd1, d);
      chk($sformatf("R4 R5 R6 R7 R8 table row %0d flags", i), d, v[7:0]);
      chk($sformatf("R9 table row %0d irq_req", i), {4'b0, irq_req},
          {4'b0, exp_req(v[7:0], 8'h27, 1'b1)});
      chk($sformatf("R10 table row %0d irq_any", i), {7'b0, irq_any},
          {7'b0, (exp_req(v[7:0], 8'h27, 1'b1) != 4'b0)});
    end

    // set all four flags, then look at the gating
    cyc(5'b10111, 1'b0, 1'b0, 2'd1, 8'h00, 4'b0);
    gie = 1'b0;
    #0.5;
    chk("R9 gie low blocks", {4'b0, irq_req}, 8'h00);
    chk("R10 gie low any", {7'b0, irq_any}, 8'h00);
    gie = 1'b1;
    cyc(5'b0, 1'b0, 1'b1, 2'd0, 8'h04, 4'b0);
    chk("R9 R3 only compare B enabled", {4'b0, irq_req}, 8'h04);
    cyc(5'b0, 1'b0, 1'b1, 2'd0, 8'hDB, 4'b0);
    rd(2'd0, d); chk("R3 R2 enable partial write", d, 8'h03);
    chk("R9 enables A and ovf", {4'b0, irq_req}, 8'h03);

    // R11 reads have no side effects; unused address reads zero
    rd(2'd1, d);
    @(negedge clk);
    rd(2'd1, d2);
    chk("R11 repeated read", d2, d);
    chk("R11 flags still set", d2, 8'h27);
    rd(2'd2, d); chk("R2 unused address", d, 8'h00);
    rd(2'd3, d); chk("R2 unused address 3", d, 8'h00);

    // R6 each ack clears only its own flag
    cyc(5'b0, 1'b0, 1'b0, 2'd1, 8'h00, 4'b0101);
    rd(2'd1, d); chk("R6 ack ovf and cmp B", d, 8'h22);

    // R1 reset in mid-run
    rst_n = 1'b0;
    #1;
    rd(2'd1, d); chk("R1 flags after mid reset", d, 8'h00);
    rd(2'd0, d); chk("R1 enable after mid reset", d, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after mid reset", {3'b0, irq_any, irq_req}, 8'h00);

    finish_run();
  end
endmodule